// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns the system clock into time quanta and walks each CAN bit through three parts: a one-quantum synchronization segment, a first phase segment that ends at the sample point, and a second phase segment that closes the bit. It emits a one-cycle strobe when a new bit begins, and a one-cycle strobe at the sample point together with the level of the receive line taken there. The receive line reaching this block is assumed to be already synchronized to the clock.

Timing comes from one packed configuration word that holds the prescaler, both segment lengths and the jump width, each stored as its real value minus one. While the bus is idle, a recessive-to-dominant edge restarts the bit at once (hard synchronization). During a frame, such an edge moves the next sample point: a late edge stretches the first phase segment and an early edge trims the second, never by more than the jump width, and only once between two sample points. Rising edges never synchronize. The jump width does not change the nominal bit rate.

Top module: `can_bit_timing`

## Requirements
- R1: `cfgTiming` holds the prescaler in bits [5:0], the first phase segment length in bits [9:6], the second phase segment length in bits [12:10] and the jump width in bits [14:13]; each field is its real value minus one, so a stored 0 means 1, and one quantum lasts (prescaler+1) clocks.
- R2: With no synchronizing edge, `bitStart` pulses for one clock every P*(1+S1+S2) clocks, where P, S1 and S2 are the real prescaler and segment lengths and the leading 1 is the fixed synchronization segment.
- R3: `sampleValid` pulses for one clock P*(1+S1) clocks after each `bitStart` pulse, and in that cycle `sampleBit` equals the level `rxIn` had at the clock edge that ended the first phase segment.
- R4: Changing only the jump width leaves the nominal bit period and sample offset unchanged.
- R5: During and right after reset, `bitStart` and `sampleValid` are 0 and `sampleBit` is 1 (recessive).
- R6: A falling edge of `rxIn` seen with `busIdle` low during quantum k (counting from 1) of the first phase segment lengthens that segment by min(k, J) quanta, J being the real jump width.
- R7: A falling edge of `rxIn` seen while `busIdle` is high restarts the bit: `bitStart` pulses in the clock after the edge is seen, and the following sample pulse comes P*(1+S1) clocks after that pulse.
- R8: A falling edge seen with `busIdle` low during the second phase segment, with r quanta of that segment left including the current one, shortens the segment by J when r > J, and restarts the bit as in R7 when r <= J.
- R9: After one resynchronization (R6 or R8) further falling edges are ignored until the next sample pulse.
- R10: Rising edges of `rxIn`, and falling edges seen with `busIdle` low during the synchronization segment, change neither the sample point nor the bit boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| cfgTiming | input | 15 | Packed timing word (prescaler, two segment lengths, jump width) |
| busIdle | input | 1 | High while no frame is on the bus; selects hard synchronization |
| rxIn | input | 1 | Synchronized receive line, 1 = recessive |
| sampleValid | output | 1 | One-clock strobe at the sample point |
| sampleBit | output | 1 | Receive level captured at the sample point |
| bitStart | output | 1 | One-clock strobe at the start of each bit |

## Verification
The in-design properties take for granted that `cfgTiming` is held steady while the unit runs and that `rxIn` is a clean synchronized level, so each transition is seen exactly once. The property that later edges leave the segment adjustment untouched also assumes such an edge does not land on the very clock in which a quantum ends. The stimulus changes the configuration only while reset is held and places every transition of the receive line in the middle of a quantum, well clear of the quantum boundaries.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

  typedef enum logic [1:0] {
    SegSync   = 2'd0,
    SegPhase1 = 2'd1,
    SegPhase2 = 2'd2
  } segState_t;

  // control -> datapath
  typedef struct packed {
    logic presRestart;
    logic sampleNow;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic tqTick;
    logic fallSeen;
  } dpEvent_t;

endpackage

// File: rtl/cbt_datapath.sv
module cbt_datapath
  import cbt_pkg::*;
#(
  parameter int PRESC_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PRESC_W-1:0] prescCfg,
  input  logic               rxIn,
  input  ctlStrobe_t         ctl,
  output dpEvent_t           ev,
  output logic               sampleBit
);

  logic [PRESC_W-1:0] presCnt;
  logic               rxPrev;

  assign ev.tqTick   = (presCnt == prescCfg);
  assign ev.fallSeen = rxPrev & ~rxIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presCnt <= '0;
    end else if (ctl.presRestart || ev.tqTick) begin
      presCnt <= '0;
    end else begin
      presCnt <= presCnt + PRESC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPrev    <= 1'b1;
      sampleBit <= 1'b1;
    end else begin
      rxPrev <= rxIn;
      if (ctl.sampleNow) sampleBit <= rxIn;
    end
  end

  // R1: with a prescaler above one, quanta never end on two adjacent clocks
  assert_quantum_spacing_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ev.tqTick && prescCfg != '0) |=> !ev.tqTick);

  // R7: a restart begins a full quantum
  assert_restart_full_quantum_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.presRestart && prescCfg != '0) |=> !ev.tqTick);

  // R3: captured level is the line level at the sample edge
  assert_sample_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sampleNow |=> (sampleBit == $past(rxIn)));

endmodule

// File: rtl/cbt_control.sv
module cbt_control
  import cbt_pkg::*;
#(
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3,
  parameter int SJW_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEG1_W-1:0] seg1Cfg,
  input  logic [SEG2_W-1:0] seg2Cfg,
  input  logic [SJW_W-1:0]  sjwCfg,
  input  logic              busIdle,
  input  dpEvent_t          ev,
  output ctlStrobe_t        ctl,
  output logic              sampleValid,
  output logic              bitStart
);

  localparam int JW_W  = SJW_W + 1;
  localparam int CNT_W = $clog2((1 << SEG1_W) + (1 << SJW_W) + 1);

  segState_t         segState;
  logic [CNT_W-1:0]  qCnt;
  logic [JW_W-1:0]   ext;
  logic [JW_W-1:0]   cut;
  logic              resyncUsed;

  logic [JW_W-1:0]   sjwLen;
  logic [JW_W-1:0]   extNew;
  logic [CNT_W-1:0]  seg1Last;
  logic [CNT_W-1:0]  phaseLate;
  logic [CNT_W-1:0]  seg2Left;
  logic              hardSync;
  logic              resyncReq;
  logic              lateResync;
  logic              earlyResync;
  logic              earlyRestart;
  logic              restart;
  logic              seg1Done;
  logic              seg2Done;

  assign sjwLen    = JW_W'(sjwCfg) + JW_W'(1);
  assign seg1Last  = CNT_W'(seg1Cfg) + CNT_W'(ext);
  assign phaseLate = qCnt + CNT_W'(1);
  assign seg2Left  = CNT_W'(seg2Cfg) + CNT_W'(1) - qCnt;
  assign extNew    = (phaseLate > CNT_W'(sjwLen)) ? sjwLen : JW_W'(phaseLate);

  assign hardSync     = ev.fallSeen && busIdle;
  assign resyncReq    = ev.fallSeen && !busIdle && !resyncUsed && (segState != SegSync);
  assign lateResync   = resyncReq && (segState == SegPhase1);
  assign earlyResync  = resyncReq && (segState == SegPhase2);
  assign earlyRestart = earlyResync && (seg2Left <= CNT_W'(sjwLen));
  assign restart      = hardSync || earlyRestart;

  assign seg1Done = ev.tqTick && !restart && (segState == SegPhase1) && (qCnt == seg1Last);
  assign seg2Done = ev.tqTick && !restart && (segState == SegPhase2) &&
                    ((qCnt + CNT_W'(cut)) >= CNT_W'(seg2Cfg));

  assign ctl.presRestart = restart;
  assign ctl.sampleNow   = seg1Done;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segState    <= SegSync;
      qCnt        <= '0;
      ext         <= '0;
      cut         <= '0;
      resyncUsed  <= 1'b0;
      sampleValid <= 1'b0;
      bitStart    <= 1'b0;
    end else begin
      sampleValid <= seg1Done;
      bitStart    <= restart || seg2Done;
      if (restart) begin
        segState   <= SegSync;
        qCnt       <= '0;
        ext        <= '0;
        cut        <= '0;
        resyncUsed <= 1'b1;
      end else begin
        if (lateResync) begin
          ext        <= extNew;
          resyncUsed <= 1'b1;
        end
        if (earlyResync) begin
          cut        <= sjwLen;
          resyncUsed <= 1'b1;
        end
        if (ev.tqTick) begin
          case (segState)
            SegSync: begin
              segState <= SegPhase1;
              qCnt     <= '0;
            end
            SegPhase1: begin
              if (seg1Done) begin
                segState <= SegPhase2;
                qCnt     <= '0;
              end else begin
                qCnt <= qCnt + CNT_W'(1);
              end
            end
            SegPhase2: begin
              if (seg2Done) begin
                segState <= SegSync;
                qCnt     <= '0;
                ext      <= '0;
                cut      <= '0;
              end else begin
                qCnt <= qCnt + CNT_W'(1);
              end
            end
            default: begin
              segState <= SegSync;
              qCnt     <= '0;
            end
          endcase
        end
        if (seg1Done) resyncUsed <= 1'b0;
      end
    end
  end

  // R2: a bit boundary always lands on the start of the sync segment
  assert_bitstart_in_sync_R2: assert property (@(posedge clk) disable iff (!rstN)
    bitStart |-> (segState == SegSync && qCnt == '0));

  // R3: the sample strobe follows the end of the first phase segment
  assert_sample_after_phase1_R3: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (segState == SegPhase2 && qCnt == '0));

  // R2: sample and bit boundary never coincide
  assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleValid && bitStart));

  // R6: lengthening never exceeds the jump width
  assert_ext_within_jump_R6: assert property (@(posedge clk) disable iff (!rstN)
    ext <= sjwLen);

  // R8: shortening never exceeds the jump width
  assert_cut_within_jump_R8: assert property (@(posedge clk) disable iff (!rstN)
    cut <= sjwLen);

  // R9: a second edge in the same sample interval moves nothing
  assert_single_resync_R9: assert property (@(posedge clk) disable iff (!rstN)
    (resyncUsed && ev.fallSeen && !busIdle && !ev.tqTick) |=> ($stable(ext) && $stable(cut)));

endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
  import cbt_pkg::*;
#(
  parameter int PRESC_W = 6,
  parameter int SEG1_W  = 4,
  parameter int SEG2_W  = 3,
  parameter int SJW_W   = 2,
  localparam int CFG_W  = PRESC_W + SEG1_W + SEG2_W + SJW_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgTiming,
  input  logic             busIdle,
  input  logic             rxIn,
  output logic             sampleValid,
  output logic             sampleBit,
  output logic             bitStart
);

  localparam int S1_LO = PRESC_W;
  localparam int S2_LO = S1_LO + SEG1_W;
  localparam int JW_LO = S2_LO + SEG2_W;

  ctlStrobe_t ctl;
  dpEvent_t   ev;

  cbt_datapath #(.PRESC_W(PRESC_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .prescCfg  (cfgTiming[PRESC_W-1:0]),
    .rxIn      (rxIn),
    .ctl       (ctl),
    .ev        (ev),
    .sampleBit (sampleBit)
  );

  cbt_control #(.SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .SJW_W(SJW_W)) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .seg1Cfg     (cfgTiming[S1_LO +: SEG1_W]),
    .seg2Cfg     (cfgTiming[S2_LO +: SEG2_W]),
    .sjwCfg      (cfgTiming[JW_LO +: SJW_W]),
    .busIdle     (busIdle),
    .ev          (ev),
    .ctl         (ctl),
    .sampleValid (sampleValid),
    .bitStart    (bitStart)
  );

endmodule

// File: tb/can_bit_timing_bench.sv
`timescale 1ns/100ps
module can_bit_timing_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic [14:0] cfgTiming;
  logic        busIdle;
  logic        rxIn;
  logic        sampleValid;
  logic        sampleBit;
  logic        bitStart;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  can_bit_timing u_can_bit_timing (
    .clk(clk), .rstN(rstN), .cfgTiming(cfgTiming), .busIdle(busIdle),
    .rxIn(rxIn), .sampleValid(sampleValid), .sampleBit(sampleBit), .bitStart(bitStart)
  );

  // columns: prescaler, seg1, seg2, jump (all stored minus one), period, sample offset
  localparam int VEC [6][6] = '{
    '{0,  0, 0, 0,  3,  2},
    '{3,  5, 2, 0, 40, 28},
    '{1, 12, 1, 0, 32, 28},
    '{11, 2, 1, 1, 72, 48},
    '{2, 15, 7, 2, 75, 51},
    '{3,  5, 2, 3, 40, 28}
  };

  function automatic logic [14:0] mkCfg(int p, int s1, int s2, int j);
    logic [5:0] pv = p[5:0];
    logic [3:0] s1v = s1[3:0];
    logic [2:0] s2v = s2[2:0];
    logic [1:0] jv = j[1:0];
    return {jv, s2v, s1v, pv};
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic applyReset(logic [14:0] cfg);
    @(negedge clk);
    rstN = 1'b0; rxIn = 1'b1; busIdle = 1'b0; cfgTiming = cfg;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitBit();
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      if (bitStart) break;
    end
  endtask

  // starts at the negedge where bitStart was seen; offsets count negedges from there
  task automatic runBit(int dropAt, int hold, int drop2,
                        output int sOff, output int sBitV, output int bOff);
    sOff = -1; sBitV = -1; bOff = -1;
    for (int n = 1; n <= 400; n++) begin
      @(negedge clk);
      if (dropAt > 0 && n == dropAt) rxIn = 1'b0;
      if (drop2 > 0 && n == drop2) rxIn = 1'b0;
      if ((dropAt > 0 && n == dropAt + hold) || (drop2 > 0 && n == drop2 + hold)) rxIn = 1'b1;
      if (sampleValid && sOff < 0) begin
        sOff  = n;
        sBitV = int'(sampleBit);
      end
      if (bitStart) begin
        bOff = n;
        break;
      end
    end
    rxIn = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s, sb, b;
    rstN = 1'b0; rxIn = 1'b1; busIdle = 1'b0;
    cfgTiming = mkCfg(3, 5, 2, 1);
    repeat (2) @(negedge clk);
    // R5 reset state
    check("R5 bitStart in reset", int'(bitStart), 0);
    check("R5 sampleValid in reset", int'(sampleValid), 0);
    check("R5 sampleBit in reset", int'(sampleBit), 1);
    rstN = 1'b1;
    @(negedge clk);
    check("R5 bitStart after reset", int'(bitStart), 0);
    check("R5 sampleValid after reset", int'(sampleValid), 0);

    // R1 R2 R3 R4: nominal timing across configurations
    for (int v = 0; v < 6; v++) begin
      applyReset(mkCfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]));
      waitBit();
      runBit(0, 0, 0, s, sb, b);
      check($sformatf("R1 R3 vec%0d sample offset", v), s, VEC[v][5]);
      check($sformatf("R2 R4 vec%0d bit period", v), b, VEC[v][4]);
      check($sformatf("R3 vec%0d sampled level", v), sb, 1);
    end

    // directed: P=4, S1=6, S2=3, J=2
    applyReset(mkCfg(3, 5, 2, 1));
    waitBit();
    runBit(0, 0, 0, s, sb, b);
    check("R3 nominal sample", s, 28);
    check("R2 nominal period", b, 40);

    runBit(5, 3, 0, s, sb, b);     // first quantum of phase 1: +1
    check("R6 late edge k=1 sample", s, 32);
    check("R6 late edge k=1 period", b, 44);

    runBit(17, 3, 0, s, sb, b);    // fourth quantum: limited to +2
    check("R6 late edge limited sample", s, 36);
    check("R6 late edge limited period", b, 48);

    runBit(5, 3, 13, s, sb, b);    // second edge ignored
    check("R9 second edge sample", s, 32);
    check("R9 second edge period", b, 44);

    runBit(29, 3, 0, s, sb, b);    // phase 2, three left: cut by 2
    check("R8 early edge sample", s, 28);
    check("R8 early edge shortened period", b, 32);
    check("R3 level before early edge", sb, 1);

    runBit(33, 3, 0, s, sb, b);    // phase 2, two left: restart
    check("R8 early edge restart period", b, 34);

    runBit(1, 35, 0, s, sb, b);    // fall in sync seg, rise in phase 2
    check("R10 sync-seg edge sample", s, 28);
    check("R10 rising edge period", b, 40);
    check("R3 dominant level sampled", sb, 0);

    busIdle = 1'b1;
    runBit(10, 3, 0, s, sb, b);
    check("R7 hard sync restart", b, 11);
    check("R7 hard sync no sample", s, -1);
    runBit(0, 0, 0, s, sb, b);
    check("R7 sample after hard sync", s, 28);
    check("R7 period after hard sync", b, 40);
    busIdle = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule